// File: doc/BRIEF.md
# Daisy-chain serial configuration receiver

This block is the serial loading front end of one device sitting in a chain of devices that share a single configuration clock. Each device receives a bit stream on its serial input and passes a re-timed copy to the next device. The receiver hunts for a 4-bit preamble and then captures a 24-bit length count. It then absorbs its own fixed number of data frames. While it absorbs them, its serial output is held High. Once its share is loaded, it forwards every further bit to the next device unchanged. The preamble and the length count are forwarded while they are captured, so every device in the chain holds the same length value.

Each device counts configuration clocks from reset release. When that count equals the captured length, the device raises start-up. Because the clock and the count are common to all devices, every device reaches this match on the same edge. User outputs are enabled two clocks after start-up. The frame count and the frame size are module parameters.

Top module: `cfg_chain_rx`

## Requirements
- R1: `din_i` is sampled on the rising edge of `clk_i`. Each forwarded bit appears on `dout_o` at the falling edge that follows its sampling edge, so a downstream device sees it one full clock later.
- R2: In the hunt state (`state_o`=0), the idle line is treated as ones and each sampled bit is forwarded. The preamble is the four bits 0,0,1,0, taken in order of arrival. The state moves to length capture (`state_o`=1) on the edge that samples the last bit of the preamble. A near miss such as 0,0,1,1 does not leave the hunt state.
- R3: The 24 bits that follow the preamble are captured as the length count, most significant bit first. They are also forwarded on `dout_o` unchanged. After the 24th bit, the state is frame load (`state_o`=2).
- R4: In the frame load state, every bit sampled produces a High on `dout_o`.
- R5: During frame load, a frame begins with a 0 start bit and is followed by FRAME_BITS-1 further bits. Ones received while waiting for a start bit are ignored. After FRAMES frames, the state becomes pass-through (`state_o`=3) and `done_o` is 1.
- R6: In the pass-through state, each sampled bit is forwarded on `dout_o` unchanged.
- R7: `startup_o` rises on the rising edge whose count since reset release equals the captured length, with the first edge after release counted as 1. The match counts only once the length has been captured. After that, `startup_o` stays High until reset.
- R8: `outs_en_o` rises exactly two rising edges after the edge that raised `startup_o`.
- R9: While `rst_ni` is low (asynchronous), all of the following hold: `state_o`=0, `startup_o`=0, `outs_en_o`=0, `done_o`=0 and `dout_o`=1. All counters and the captured length are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 1 | Serial configuration data in |
| dout_o | output | 1 | Re-timed serial data to next device |
| startup_o | output | 1 | Length-count match reached (sticky) |
| outs_en_o | output | 1 | User outputs released |
| done_o | output | 1 | Own frames loaded |
| state_o | output | 2 | 0 hunt, 1 length, 2 load, 3 pass-through |

## Verification
The bench chains two instances. The first is built with FRAMES=2, FRAME_BITS=4 and the second with FRAMES=3, FRAME_BITS=5, both with a 24-bit length. These small frame sizes bring the whole sequence within about seventy clocks: hunt, length capture, load, pass-through and the common start-up edge. Because the two devices differ in size, the downstream device must wait through the upstream device's High run for its own start bits. A second run adds a near-miss preamble and an idle gap between frames, with a different length value.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LEN  = 2'd1,
    ST_LOAD = 2'd2,
    ST_PASS = 2'd3
  } cfg_state_e;

  localparam logic [3:0] PREAMBLE = 4'b0010;
endpackage

// File: rtl/cfg_chain_fsm.sv
module cfg_chain_fsm
  import cfg_chain_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       din_i,
  output cfg_state_e state_o
);
  localparam int LCW = $clog2(LEN_W);
  localparam int FCW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int BCW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  cfg_state_e     st_q;
  logic [2:0]     hist_q;
  logic [LCW-1:0] len_cnt_q;
  logic [FCW-1:0] frm_cnt_q;
  logic [BCW-1:0] bit_cnt_q;
  logic           in_frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      hist_q     <= 3'b111;
      len_cnt_q  <= '0;
      frm_cnt_q  <= '0;
      bit_cnt_q  <= '0;
      in_frame_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[1:0], din_i};
      case (st_q)
        ST_HUNT: begin
          len_cnt_q <= '0;
          if ({hist_q, din_i} == PREAMBLE) st_q <= ST_LEN;
        end
        ST_LEN: begin
          if (len_cnt_q == LCW'(LEN_W - 1)) st_q <= ST_LOAD;
          else len_cnt_q <= len_cnt_q + LCW'(1);
        end
        ST_LOAD: begin
          if (!in_frame_q) begin
            // ones between frames are idle
            if (!din_i) begin
              in_frame_q <= 1'b1;
              bit_cnt_q  <= BCW'(1);
            end
          end else if (bit_cnt_q == BCW'(FRAME_BITS - 1)) begin
            in_frame_q <= 1'b0;
            bit_cnt_q  <= '0;
            if (frm_cnt_q == FCW'(FRAMES - 1)) st_q <= ST_PASS;
            else frm_cnt_q <= frm_cnt_q + FCW'(1);
          end else begin
            bit_cnt_q <= bit_cnt_q + BCW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o = st_q;

  assert_legal_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PASS) |=> (st_q == ST_PASS));
  assert_hunt_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT) |=> (st_q == ST_HUNT || st_q == ST_LEN));
  assert_len_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEN) |=> (st_q == ST_LEN || st_q == ST_LOAD));
endmodule

// File: rtl/cfg_chain_start.sv
module cfg_chain_start #(
  parameter int LEN_W = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic len_en_i,
  input  logic len_ok_i,
  output logic startup_o,
  output logic outs_en_o
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nx;
  logic             start_q;
  logic [1:0]       rel_q;

  assign cnt_nx = cnt_q + LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      rel_q   <= '0;
    end else begin
      if (len_en_i) len_q <= {len_q[LEN_W-2:0], din_i};
      if (!start_q) begin
        cnt_q <= cnt_nx;
        if (len_ok_i && cnt_nx == len_q) start_q <= 1'b1;
      end
      rel_q <= {rel_q[0], start_q};
    end
  end

  assign startup_o = start_q;
  assign outs_en_o = rel_q[1];

  assert_start_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    startup_o |=> startup_o);
  assert_release_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(startup_o) |-> !outs_en_o ##1 !outs_en_o ##1 outs_en_o);
endmodule

// File: rtl/cfg_chain_dout.sv
module cfg_chain_dout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic hold_hi_i,
  output logic dout_o
);
  logic fwd_q;
  logic dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_q <= 1'b1;
    else         fwd_q <= hold_hi_i | din_i;
  end

  // re-time on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= 1'b1;
    else         dout_q <= fwd_q;
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       din_i,
  output logic       dout_o,
  output logic       startup_o,
  output logic       outs_en_o,
  output logic       done_o,
  output logic [1:0] state_o
);
  cfg_state_e st;

  cfg_chain_fsm #(
    .LEN_W(LEN_W), .FRAMES(FRAMES), .FRAME_BITS(FRAME_BITS)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_i), .state_o(st)
  );

  cfg_chain_start #(.LEN_W(LEN_W)) u_start (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_i),
    .len_en_i(st == ST_LEN),
    .len_ok_i(st == ST_LOAD || st == ST_PASS),
    .startup_o(startup_o), .outs_en_o(outs_en_o)
  );

  cfg_chain_dout u_dout (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_i),
    .hold_hi_i(st == ST_LOAD), .dout_o(dout_o)
  );

  assign state_o = st;
  assign done_o  = (st == ST_PASS);

  assert_load_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LOAD) |=> dout_o);
  assert_start_after_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    startup_o |-> (st == ST_LOAD || st == ST_PASS));
endmodule

// File: tb/cfg_chain_rx_tb_top.sv
`timescale 1ns/1ps
module cfg_chain_rx_tb_top;
  localparam int NS = 80;
  // segment table for run 1: {bit count, value}, sent MSB first
  localparam logic [28:0] SEG1 [8] = '{
    {5'd4, 24'hF}, {5'd4, 24'h2}, {5'd24, 24'd64}, {5'd4, 24'h5},
    {5'd4, 24'h3}, {5'd5, 24'hD}, {5'd5, 24'h7}, {5'd5, 24'hA}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic d01, d1o, st0, st1, oe0, oe1, dn0, dn1;
  logic [1:0] s0, s1;
  logic s [NS];
  int pos, checks = 0, failures = 0;
  int cl, cg;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_chain_rx #(.FRAMES(2), .FRAME_BITS(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .dout_o(d01),
    .startup_o(st0), .outs_en_o(oe0), .done_o(dn0), .state_o(s0));
  cfg_chain_rx #(.FRAMES(3), .FRAME_BITS(5)) dut1_i (
    .clk_i(clk), .rst_ni(rst_n), .din_i(d01), .dout_o(d1o),
    .startup_o(st1), .outs_en_o(oe1), .done_o(dn1), .state_o(s1));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [23:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) begin s[pos] = v[k]; pos++; end
  endtask

  function automatic logic f0(input int j);
    if (j < 0) return 1'b1;
    if (j >= cl + 24 && j < cl + 32 + cg) return 1'b1;
    return s[j];
  endfunction

  function automatic logic f1(input int j);
    if (j < 0) return 1'b1;
    if (j >= cl + 25 && j < cl + 48 + cg) return 1'b1;
    return (j == 0) ? 1'b1 : f0(j - 1);
  endfunction

  function automatic int est(input int i, input int off);
    if (i < cl + off) return 0;
    if (i < cl + off + 24) return 1;
    if (off == 0) return (i < cl + 32 + cg) ? 2 : 3;
    return (i < cl + 48 + cg) ? 2 : 3;
  endfunction

  function automatic string rtag(input int j, input int off);
    if (j < cl + off) return "R1,R2";
    if (j < cl + off + 24) return "R1,R3";
    if (j < cl + off + 24 + ((off == 0) ? 8 : 23) + cg) return "R1,R4";
    return "R1,R6";
  endfunction

  task automatic check_reset();
    check(s0 == 2'd0 && s1 == 2'd0, "R9", "reset state", s0, 0);
    check(!st0 && !st1 && !oe0 && !oe1, "R9", "reset startup/outs", st0 | oe0, 0);
    check(!dn0 && !dn1, "R9", "reset done", dn0, 0);
    check(d01 && d1o, "R9", "reset dout", d01, 1);
  endtask

  task automatic run_chain(input int l, input int g, input int len);
    int e0, e1;
    cl = l; cg = g;
    @(negedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < len + 5; i++) begin
      #1;
      check(d01 == ((i == 0) ? 1'b1 : f0(i - 1)), rtag(i - 1, 0), "dout dev0",
            d01, (i == 0) ? 1 : f0(i - 1));
      check(d1o == ((i == 0) ? 1'b1 : f1(i - 1)), rtag(i - 1, 1), "dout dev1",
            d1o, (i == 0) ? 1 : f1(i - 1));
      e0 = est(i, 0); e1 = est(i, 1);
      check(s0 == 2'(e0), "R2,R3,R5", "state dev0", s0, e0);
      check(s1 == 2'(e1), "R2,R3,R5", "state dev1", s1, e1);
      check(dn0 == (e0 == 3) && dn1 == (e1 == 3), "R5", "done", dn0 + 2*dn1,
            (e0 == 3) + 2*(e1 == 3));
      check(st0 == (i >= len) && st1 == (i >= len), "R7", "startup",
            st0 + 2*st1, 3*(i >= len));
      check(oe0 == (i >= len + 2) && oe1 == (i >= len + 2), "R8", "outs_en",
            oe0 + 2*oe1, 3*(i >= len + 2));
      din = (i < NS) ? s[i] : 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) s[k] = 1'b1;
    pos = 0;
    foreach (SEG1[k]) put(SEG1[k][23:0], int'(SEG1[k][28:24]));
    repeat (3) @(negedge clk);
    #2 check_reset();
    // run 1: plain header, contiguous frames, length 64
    run_chain(8, 0, 64);
    // R9: asynchronous reset in the middle of the idle tail
    #3 rst_n = 1'b0; din = 1'b1;
    #1 check_reset();
    // run 2: near-miss preamble, gap of two idle ones between frames of dev0
    for (int k = 0; k < NS; k++) s[k] = 1'b1;
    pos = 0;
    put(24'h3, 2); put(24'h32, 8); put(24'd62, 24);
    put(24'h5, 4); put(24'h3, 2); put(24'h3, 4);
    put(24'hD, 5); put(24'h7, 5); put(24'hA, 5);
    repeat (2) @(negedge clk);
    run_chain(10, 2, 62);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule